// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor with Acknowledge

This block collects a parameterised set of level-sensitive interrupt lines and spreads each one to the CPUs that software has chosen for it. Each source has a global enable and a routing word that holds a CPU bitmask. Each CPU has its own per-source mask. A source is eligible for a CPU when all of these hold: its line is high, it is enabled, it is routed to that CPU and that CPU has not masked it. Each CPU receives one interrupt output, which is the OR of everything eligible for it.

Software programs the block over a plain 32-bit register bus. A `bus_cpu` input says which CPU is making the access, and the per-CPU registers act on that CPU. Enables and masks are never changed by rewriting a bitmap. Instead, a source number is written to a set or clear register. Reading the acknowledge register gives the lowest-numbered eligible source for the reading CPU. Identifier 0 is reserved for a per-CPU doorbell summary input. A reserved code of 1023 means nothing is pending. The read changes no state: the sources are levels, so a source disappears only when its line falls, its enable is cleared or it is masked.

Top module: `mp_irq_distributor`

## Requirements
- R1: After reset every enable is clear, every routing word is 0, every per-CPU mask bit is set, `cpu_irq` is all zero and an acknowledge read returns 1023.
- R2: A read of address 0x000 returns the number of implemented sources in bits [11:2]; all other bits read 0.
- R3: Writing a source number (bits [9:0] of the write data) to 0x030 sets that source's global enable; writing it to 0x034 clears it.
- R4: The routing word of source s lives at 0x100 + 4*s; bit c routes the source to CPU c, it reads back, and bits at or above the CPU count read 0.
- R5: Writing a source number to 0x048 masks that source for the accessing CPU only; writing it to 0x04C unmasks it for that CPU only.
- R6: A read of 0x044 returns, in bits [9:0] of `bus_rdata` on the cycle after `bus_rd`, the lowest-numbered eligible source for the accessing CPU, or 1023 when none is eligible; bits [31:10] read 0.
- R7: Source 0 is eligible for CPU c exactly when `doorbell[c]` is high and CPU c has bit 0 unmasked; the enable and routing of source 0 play no part.
- R8: An acknowledge read clears nothing; a source stops being reported as soon as its line drops or its enable is cleared.
- R9: A source routed to several CPUs is eligible for, and acknowledged by, each of them.
- R10: `cpu_irq[c]` is high in the same cycle as any source is eligible for CPU c, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cpu | input | CPU_W | Index of the CPU making the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| src_level | input | NUM_SRC | Interrupt lines; bit 0 is unused |
| doorbell | input | NUM_CPU | Per-CPU doorbell summary (source 0) |
| cpu_irq | output | NUM_CPU | Per-CPU interrupt request |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together, and that `bus_cpu` always names an implemented CPU when a strobe is high. They also assume that the interrupt lines and doorbells are stable levels sampled at the clock edge. The stimulus drives every input on the falling edge and issues one access at a time, each with a legal CPU index. The expected acknowledge value is worked out from the enables, routes, masks and lines in force at the rising edge that samples the read.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  localparam int ADDR_W = 12;
  localparam int ID_W   = 10;
  localparam logic [ID_W-1:0] ID_NONE = '1;

  localparam logic [ADDR_W-1:0] A_CTRL     = 12'h000;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 12'h030;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 12'h034;
  localparam logic [ADDR_W-1:0] A_ACK      = 12'h044;
  localparam logic [ADDR_W-1:0] A_MSK_SET  = 12'h048;
  localparam logic [ADDR_W-1:0] A_MSK_CLR  = 12'h04C;
  localparam logic [ADDR_W-1:0] A_ROUTE_LO = 12'h100;

  function automatic logic [31:0] ctrl_word(input int n_src);
    return 32'(n_src) << 2;
  endfunction

  function automatic logic in_route_window(input logic [ADDR_W-1:0] a, input int n_src);
    int top_addr;
    top_addr = int'(A_ROUTE_LO) + 4 * n_src;
    return (int'(a) >= int'(A_ROUTE_LO)) && (int'(a) < top_addr) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [ADDR_W-1:0] route_slot(input logic [ADDR_W-1:0] a);
    return (a - A_ROUTE_LO) >> 2;
  endfunction
endpackage

// File: rtl/mpd_regs.sv
module mpd_regs
  import mpd_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2,
  parameter int SRC_W   = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [CPU_W-1:0]                  bus_cpu,
  input  logic                              bus_wr,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [31:0]                       bus_wdata,
  output logic [NUM_SRC-1:0]                en_o,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_o,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_o
);
  logic [NUM_SRC-1:0]              en_q;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q;

  // Decoded write events, named for the assertions
  logic [ID_W-1:0]   wr_id;
  logic [SRC_W-1:0]  wr_sidx;
  logic [ADDR_W-1:0] slot_full;
  logic [SRC_W-1:0]  route_sidx;
  logic              id_ok, cpu_ok;
  logic              ev_en_set, ev_en_clr, ev_msk_set, ev_msk_clr, ev_route;

  assign wr_id      = bus_wdata[ID_W-1:0];
  assign wr_sidx    = wr_id[SRC_W-1:0];
  assign slot_full  = route_slot(bus_addr);
  assign route_sidx = slot_full[SRC_W-1:0];
  assign id_ok      = int'(wr_id) < NUM_SRC;
  assign cpu_ok     = int'(bus_cpu) < NUM_CPU;

  assign ev_en_set  = bus_wr && (bus_addr == A_EN_SET)  && id_ok;
  assign ev_en_clr  = bus_wr && (bus_addr == A_EN_CLR)  && id_ok;
  assign ev_msk_set = bus_wr && (bus_addr == A_MSK_SET) && id_ok && cpu_ok;
  assign ev_msk_clr = bus_wr && (bus_addr == A_MSK_CLR) && id_ok && cpu_ok;
  assign ev_route   = bus_wr && in_route_window(bus_addr, NUM_SRC);

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:ID_W], slot_full};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
      mask_q  <= '1;
    end else begin
      if (ev_en_set)  en_q[wr_sidx] <= 1'b1;
      if (ev_en_clr)  en_q[wr_sidx] <= 1'b0;
      if (ev_msk_set) mask_q[bus_cpu][wr_sidx] <= 1'b1;
      if (ev_msk_clr) mask_q[bus_cpu][wr_sidx] <= 1'b0;
      if (ev_route)   route_q[route_sidx] <= bus_wdata[NUM_CPU-1:0];
    end
  end

  assign en_o    = en_q;
  assign route_o = route_q;
  assign mask_o  = mask_q;

  // R3: indexed enable set / clear land on the named source
  a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_en_set |=> en_q[$past(wr_sidx)]);
  a_r3_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_en_clr |=> !en_q[$past(wr_sidx)]);
  // R5: indexed mask set / clear land on the accessing CPU
  a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_msk_set |=> mask_q[$past(bus_cpu)][$past(wr_sidx)]);
  a_r5_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_msk_clr |=> !mask_q[$past(bus_cpu)][$past(wr_sidx)]);
  // R8: reads and idle cycles leave all configuration untouched
  a_r8_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(en_q) && $stable(mask_q) && $stable(route_q)));
endmodule

// File: rtl/mpd_pick.sv
module mpd_pick
  import mpd_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] req,
  output logic [ID_W-1:0]    id,
  output logic               any
);
  // Lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    id = ID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) id = ID_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/mp_irq_distributor.sv
module mp_irq_distributor
  import mpd_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic [NUM_CPU-1:0] doorbell,
  output logic [NUM_CPU-1:0] cpu_irq
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0]              en_w;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route_w;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_w;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] elig;
  logic [NUM_CPU-1:0][ID_W-1:0]    ack_id;

  mpd_regs #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .SRC_W(SRC_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .en_o(en_w), .route_o(route_w), .mask_o(mask_w)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    // Source 0 is the doorbell summary; others need line, enable and route
    assign elig[c][0] = doorbell[c] & ~mask_w[c][0];
    for (genvar s = 1; s < NUM_SRC; s++) begin : g_src
      assign elig[c][s] = src_level[s] & en_w[s] & route_w[s][c] & ~mask_w[c][s];
    end

    mpd_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .req(elig[c]), .id(ack_id[c]), .any(cpu_irq[c])
    );

    // R10: with no lines and no doorbell there is nothing to request
    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_level == '0) && !doorbell[c]) |-> !cpu_irq[c]);
    // R7: an unmasked doorbell always raises the CPU request
    a_r7_doorbell_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (doorbell[c] && !mask_w[c][0]) |-> cpu_irq[c]);
  end

  // Read events, named for the assertions
  logic reader_ok, rd_ack, rd_ctrl, rd_route, reader_irq;
  logic [ADDR_W-1:0] rslot;
  logic [SRC_W-1:0]  rsidx;

  assign reader_ok  = int'(bus_cpu) < NUM_CPU;
  assign rd_ack     = bus_rd && (bus_addr == A_ACK) && reader_ok;
  assign rd_ctrl    = bus_rd && (bus_addr == A_CTRL);
  assign rd_route   = bus_rd && in_route_window(bus_addr, NUM_SRC);
  assign rslot      = route_slot(bus_addr);
  assign rsidx      = rslot[SRC_W-1:0];
  assign reader_irq = reader_ok && cpu_irq[bus_cpu];

  logic unused_rslot;
  assign unused_rslot = ^rslot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (rd_ctrl)       bus_rdata <= ctrl_word(NUM_SRC);
      else if (rd_ack)   bus_rdata <= 32'(ack_id[bus_cpu]);
      else if (rd_route) bus_rdata <= 32'(route_w[rsidx]);
      else               bus_rdata <= '0;
    end
  end

  // R2: control word reports the source count
  a_r2_ctrl_count: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> bus_rdata == 32'(NUM_SRC * 4));
  // R6: acknowledge returns the idle code when nothing is eligible
  a_r6_ack_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !reader_irq) |=> bus_rdata == 32'(ID_NONE));
  // R6: acknowledge returns an implemented identifier when something is eligible
  a_r6_ack_valid_id: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && reader_irq) |=> (bus_rdata[31:ID_W] == '0) && (int'(bus_rdata[ID_W-1:0]) < NUM_SRC));
endmodule

// File: tb/test_mp_irq_distributor.sv
module test_mp_irq_distributor;
  localparam int NS = 32;
  localparam int NC = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  bus_cpu = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] src_level = 0;
  logic [NC-1:0] doorbell = 0;
  logic [NC-1:0] cpu_irq;

  always #10 clk = ~clk; // 50 MHz

  mp_irq_distributor #(.NUM_SRC(NS), .NUM_CPU(NC)) i_mp_irq_distributor (
    .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_level(src_level), .doorbell(doorbell), .cpu_irq(cpu_irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: a read sampled at a rising edge is compared at the next falling edge
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata === e, t, bus_rdata, e);
    end
  end

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_cpu = 2'(cpu); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_cpu = 2'(cpu); bus_addr = a; bus_rd = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic chk_irq(input logic [NC-1:0] e, input string tag);
    chk(cpu_irq === e, tag, 32'(cpu_irq), 32'(e));
  endtask

  function automatic logic [11:0] route_at(input int s);
    return 12'(256 + 4 * s);
  endfunction

  localparam logic [31:0] NONE = 32'd1023;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk_irq(4'b0000, "R1 irq after reset");
    rd(0, 12'h044, NONE, "R1 ack after reset");
    rd(3, 12'h044, NONE, "R1 ack cpu3 after reset");
    rd(0, route_at(5), 32'h0, "R1 route after reset");
    // R2: control word
    rd(1, 12'h000, 32'(NS) << 2, "R2 source count");
    // R4: routing words
    wr(0, route_at(5), 32'h3);
    wr(0, route_at(9), 32'h1);
    rd(2, route_at(5), 32'h3, "R4 route readback");
    src_level[5] = 1; src_level[9] = 1;
    @(negedge clk);
    chk_irq(4'b0000, "R3 disabled source silent");
    wr(0, 12'h030, 32'd5);
    chk_irq(4'b0000, "R5 masked by default");
    wr(0, 12'h04C, 32'd5);
    chk_irq(4'b0001, "R10 irq on unmask cpu0");
    rd(0, 12'h044, 32'd5, "R6 ack cpu0 src5");
    // R9: second CPU takes the same source
    wr(1, 12'h04C, 32'd5);
    chk_irq(4'b0011, "R9 both cpus requested");
    rd(1, 12'h044, 32'd5, "R9 ack cpu1 src5");
    rd(0, 12'h044, 32'd5, "R8 ack repeat still src5");
    // R6: lowest wins; R5: per-CPU mask
    wr(0, 12'h030, 32'd9);
    wr(0, 12'h04C, 32'd9);
    rd(0, 12'h044, 32'd5, "R6 lowest of 5 and 9");
    wr(0, 12'h048, 32'd5);
    rd(0, 12'h044, 32'd9, "R5 cpu0 masked src5");
    rd(1, 12'h044, 32'd5, "R5 cpu1 unaffected");
    // R3/R8: clearing enable removes source
    wr(2, 12'h034, 32'd5);
    chk_irq(4'b0001, "R8 disable drops cpu1");
    rd(1, 12'h044, NONE, "R3 cleared enable cpu1");
    rd(0, 12'h044, 32'd9, "R3 cpu0 still src9");
    // R8: line drop
    src_level[9] = 0;
    @(negedge clk);
    chk_irq(4'b0000, "R8 line drop irq");
    rd(0, 12'h044, NONE, "R8 line drop ack");
    // R7: doorbell
    doorbell[2] = 1;
    @(negedge clk);
    chk_irq(4'b0000, "R7 doorbell masked");
    wr(2, 12'h04C, 32'd0);
    chk_irq(4'b0100, "R7 doorbell unmasked");
    src_level[9] = 1;
    wr(0, route_at(9), 32'h5);
    wr(2, 12'h04C, 32'd9);
    rd(2, 12'h044, 32'd0, "R7 doorbell id 0 wins");
    doorbell[2] = 0;
    rd(2, 12'h044, 32'd9, "R6 cpu2 src9 after doorbell");
    // R4: upper bits dropped, other slot
    wr(0, route_at(12), 32'hFFFF_FFFF);
    rd(0, route_at(12), 32'hF, "R4 upper bits read 0");
    wr(0, route_at(31), 32'hA);
    rd(3, route_at(31), 32'hA, "R4 last slot");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk(1'b0, "monitor queue drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule